// File: doc/BRIEF.md
# Configurable LUT Cell Array

This block is a reconfigurable combinational fabric made of a grid of small programmable cells, eight rows by four columns. Each cell holds a three-input lookup table, and each of the three table inputs is picked by its own eight-way selector. A cell can therefore act as any three-input logic function, or as a plain wire when its table copies one selected input to its output. The cells in the first column choose among the eight primary inputs. Every later column chooses among the eight outputs of the column to its left. The eight outputs of the last column are registered to form the array output.

All table contents and selector codes come from one flat configuration word of 544 bits, which is 17 bits per cell. The word is shifted in serially, one bit per clock, while the load enable is high. A one-cycle completion pulse marks the end of a full load. A search engine outside this block can rewrite the word at any time to try a new circuit, and then read the resulting outputs for any input pattern.

Top module: `lutarr_top`

## Requirements
- R1: After reset, out_vec is 0 and cfg_done is 0. The configuration word is all zeros, so out_vec stays 0 for every in_vec until a load is made.
- R2: Each cell outputs bit 9+i of its slice, where i = 4*in2 + 2*in1 + in0. Slice bits [16:9] hold the truth table.
- R3: Within a cell slice, bits [2:0] select table input 0, bits [5:3] select input 1 and bits [8:6] select input 2. A select value s picks candidate s.
- R4: In column 0, candidate s is in_vec[s]. In column c>0, candidate s is the output of row s in column c-1.
- R5: The cell in column c and row r uses bits [17k+16:17k] of the 544-bit configuration word, with k = 8c + r.
- R6: While cfg_en is high, each clock shifts cfg_bit in. After 544 shifts, the first bit sent sits at word position 543 and the last at position 0, so the cell in column 0, row 0 is loaded last.
- R7: cfg_done is high for exactly one cycle, the cycle after the clock edge that makes the 544th enabled shift. Cycles with cfg_en low do not advance the shift count, and the count starts over after each pulse.
- R8: With cfg_en low, out_vec takes the outputs of the last column at every clock edge. A change of in_vec therefore appears on out_vec after the next edge.
- R9: While cfg_en is high, out_vec keeps its value whatever in_vec does.
- R10: While cfg_en is low, cfg_bit has no effect on the configuration word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Serial load enable: shift one configuration bit per clock |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_done | output | 1 | One-cycle pulse after a complete 544-bit load |
| in_vec | input | 8 | Primary inputs feeding column 0 |
| out_vec | output | 8 | Registered outputs of the last column |

## Verification
The hardest state to reach from the ports is a full 544-bit word in which every table and every selector field holds a chosen value. Each such word needs its own complete serial load. The bench builds each word as a bit image and streams it in. It uses all-zero words, pass-through and rotating-routing words, words that program a single cell so that position errors show, and words filled from a pseudo-random generator. For each loaded word it sweeps all 256 input patterns against an arithmetic model of the grid. One load is broken by idle gaps with cfg_bit toggling, to check that the shift count survives the gaps and that the toggled bits are ignored. Another load runs while in_vec keeps changing, to check that out_vec holds.

// File: rtl/lutarr_pkg.sv
package lutarr_pkg;
  localparam int LUT_K   = 3;
  localparam int TT_BITS = 1 << LUT_K;

  // truth-table lookup: table entry indexed by {in2,in1,in0}
  function automatic logic lut_eval(input logic [TT_BITS-1:0] tt,
                                    input logic [LUT_K-1:0]   idx);
    return tt[idx];
  endfunction

  function automatic int cell_bits(input int sel_w);
    return TT_BITS + LUT_K * sel_w;
  endfunction
endpackage

// File: rtl/lutarr_cell.sv
module lutarr_cell
  import lutarr_pkg::*;
#(
  parameter int NCAND = 8,
  localparam int SEL_W = $clog2(NCAND),
  localparam int CBITS = TT_BITS + LUT_K * SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCAND-1:0] cand,
  input  logic [CBITS-1:0] cfg,
  output logic             y
);
  logic [SEL_W-1:0]   sel [LUT_K];
  logic [LUT_K-1:0]   lut_in;
  logic [TT_BITS-1:0] tt;

  assign tt = cfg[CBITS-1 -: TT_BITS];

  for (genvar k = 0; k < LUT_K; k++) begin : g_mux
    assign sel[k]    = cfg[k*SEL_W +: SEL_W];
    assign lut_in[k] = cand[sel[k]];
  end

  assign y = lut_eval(tt, lut_in);

  // constant tables force the output regardless of routing
  assert_const0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tt == '0) |-> !y);
  assert_const1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tt == '1) |-> y);
  // copy tables route the selected candidate straight through
  assert_route0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tt == 8'hAA) |-> (y == cand[cfg[SEL_W-1:0]]));
  assert_route2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tt == 8'hF0) |-> (y == cand[cfg[3*SEL_W-1 -: SEL_W]]));
endmodule

// File: rtl/lutarr_cfg_chain.sv
module lutarr_cfg_chain #(
  parameter int TOTAL = 544,
  localparam int CW   = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [TOTAL-1:0] cfg_word,
  output logic             done
);
  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

  logic [CW-1:0] cnt;
  logic          last_shift;

  assign last_shift = shift_en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_word <= '0;
      cnt      <= '0;
      done     <= 1'b0;
    end else begin
      done <= last_shift;
      if (shift_en) begin
        cfg_word <= {cfg_word[TOTAL-2:0], bit_in};
        cnt      <= last_shift ? '0 : cnt + 1'b1;
      end
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(shift_en));
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(cfg_word));
  assert_shift_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (cfg_word[0] == $past(bit_in)));
endmodule

// File: rtl/lutarr_top.sv
module lutarr_top
  import lutarr_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 4,
  localparam int SEL_W = $clog2(ROWS),
  localparam int CBITS = TT_BITS + LUT_K * SEL_W,
  localparam int TOTAL = ROWS * COLS * CBITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_bit,
  output logic            cfg_done,
  input  logic [ROWS-1:0] in_vec,
  output logic [ROWS-1:0] out_vec
);
  logic [TOTAL-1:0]     cfg_word;
  logic [ROWS*COLS-1:0] cell_y;
  logic [ROWS-1:0]      last_col;
  logic                 sample_en;

  lutarr_cfg_chain #(.TOTAL(TOTAL)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .bit_in   (cfg_bit),
    .cfg_word (cfg_word),
    .done     (cfg_done)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] cand;
    if (c == 0) begin : g_first
      assign cand = in_vec;
    end else begin : g_next
      assign cand = cell_y[(c-1)*ROWS +: ROWS];
    end
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      lutarr_cell #(.NCAND(ROWS)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .cand  (cand),
        .cfg   (cfg_word[(c*ROWS+r)*CBITS +: CBITS]),
        .y     (cell_y[c*ROWS+r])
      );
    end
  end

  assign last_col  = cell_y[(COLS-1)*ROWS +: ROWS];
  assign sample_en = !cfg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_vec <= '0;
    else if (sample_en) out_vec <= last_col;
  end

  assert_hold_in_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(out_vec));
  assert_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (out_vec == $past(last_col)));
endmodule

// File: tb/tb_lutarr_top.sv
`timescale 1ns/1ps
module tb_lutarr_top;
  localparam int NR = 8, NC = 4, CB = 17, TOT = NR * NC * CB;

  logic clk = 1'b0, rst_n = 1'b0, cfg_en = 1'b0, cfg_bit = 1'b0;
  logic cfg_done;
  logic [7:0] in_vec = '0, out_vec;
  logic [TOT-1:0] img;
  int total = 0, bad = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  lutarr_top dut (.clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
                  .cfg_done(cfg_done), .in_vec(in_vec), .out_vec(out_vec));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic set_cell(input int c, input int r, input logic [7:0] tt,
                          input int s2, input int s1, input int s0);
    int base;
    base = (c * NR + r) * CB;
    for (int b = 0; b < 3; b++) begin
      img[base + b]     = s0[b];
      img[base + 3 + b] = s1[b];
      img[base + 6 + b] = s2[b];
    end
    for (int b = 0; b < 8; b++) img[base + 9 + b] = tt[b];
  endtask

  // arithmetic model of the grid
  function automatic logic [7:0] model(input logic [TOT-1:0] w, input logic [7:0] x);
    logic [7:0] cur, nxt;
    int base, idx, s;
    cur = x;
    for (int c = 0; c < NC; c++) begin
      for (int r = 0; r < NR; r++) begin
        base = (c * NR + r) * CB;
        idx = 0;
        for (int k = 0; k < 3; k++) begin
          s = 4 * w[base + 3*k + 2] + 2 * w[base + 3*k + 1] + w[base + 3*k];
          idx = idx + (cur[s] ? (1 << k) : 0);
        end
        nxt[r] = w[base + 9 + idx];
      end
      cur = nxt;
    end
    return cur;
  endfunction

  task automatic load(input bit gaps, input bit hold);
    logic [7:0] held;
    held = out_vec;
    for (int i = TOT - 1; i >= 0; i--) begin
      @(negedge clk);
      if (i != TOT - 1) chk(cfg_done == 1'b0, "R7", "done early", cfg_done, 0);
      if (hold) begin
        chk(out_vec == held, "R9", "output moved during load", out_vec, held);
        in_vec = 8'(rnd());
      end
      if (gaps && (i % 97 == 50)) begin
        cfg_en = 1'b0;
        for (int g = 0; g < 3; g++) begin
          cfg_bit = ~cfg_bit;
          @(negedge clk);
          chk(cfg_done == 1'b0, "R7", "done during gap", cfg_done, 0);
        end
      end
      cfg_en  = 1'b1;
      cfg_bit = img[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    chk(cfg_done == 1'b1, "R7", "done pulse missing", cfg_done, 1);
    if (hold) chk(out_vec == held, "R9", "output moved on last shift", out_vec, held);
    @(negedge clk);
    chk(cfg_done == 1'b0, "R7", "done wider than one cycle", cfg_done, 0);
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      in_vec = 8'(v);
      @(negedge clk);
      chk(out_vec == model(img, 8'(v)), req, "sweep", out_vec, model(img, 8'(v)));
    end
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    img = '0;
    repeat (3) @(negedge clk);
    chk(out_vec == 8'h00, "R1", "reset output", out_vec, 0);
    chk(cfg_done == 1'b0, "R1", "reset done", cfg_done, 0);
    rst_n = 1'b1;
    sweep("R1");

    // pass-through identity routing: out == in
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++) set_cell(c, r, 8'hAA, 0, 0, r);
    load(1'b0, 1'b0);
    for (int v = 0; v < 256; v += 17) begin
      @(negedge clk); in_vec = 8'(v);
      @(negedge clk); chk(out_vec == 8'(v), "R4", "identity routing", out_vec, v);
    end
    // one-edge latency of the output register
    @(negedge clk); in_vec = 8'h5A;
    @(negedge clk); in_vec = 8'hC3;
    #1 chk(out_vec == 8'h5A, "R8", "changed before edge", out_vec, 8'h5A);
    @(negedge clk);
    chk(out_vec == 8'hC3, "R8", "sampled after edge", out_vec, 8'hC3);

    // rotating routing on each table input position
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++) set_cell(c, r, 8'hAA, 7, 6, (r + 1) % 8);
    load(1'b0, 1'b0);
    sweep("R3");
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++) set_cell(c, r, 8'hCC, 0, (r + c + 1) % 8, 5);
    load(1'b0, 1'b0);
    sweep("R3");
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++) set_cell(c, r, 8'hF0, (r + 3) % 8, 1, 2);
    load(1'b0, 1'b0);
    sweep("R4");

    // cell position: only last column, row 5 constant one
    img = '0;
    set_cell(3, 5, 8'hFF, 0, 0, 0);
    load(1'b0, 1'b0);
    for (int v = 0; v < 256; v += 51) begin
      @(negedge clk); in_vec = 8'(v);
      @(negedge clk); chk(out_vec == 8'h20, "R5", "single cell position", out_vec, 8'h20);
    end
    // cell 0 is loaded last; row 0 chain copies in_vec[2]
    img = '0;
    set_cell(0, 0, 8'hAA, 0, 0, 2);
    for (int c = 1; c < NC; c++) set_cell(c, 0, 8'hAA, 0, 0, 0);
    load(1'b0, 1'b0);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk); in_vec = 8'(1 << v);
      @(negedge clk);
      chk(out_vec == ((v == 2) ? 8'h01 : 8'h00), "R6", "bit order", out_vec,
          (v == 2) ? 8'h01 : 8'h00);
    end

    // random tables and selects
    for (int t = 0; t < 3; t++) begin
      for (int b = 0; b < TOT; b++) img[b] = rnd() >> 16;
      load(t == 1, 1'b0);
      sweep(t == 1 ? "R10" : "R2");
    end

    // hold while loading with moving inputs
    for (int b = 0; b < TOT; b++) img[b] = rnd() >> 16;
    load(1'b0, 1'b1);
    sweep("R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule